// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Interrupt Check

This block is the control-state engine of a small stored-program processor. It moves the processor through a fixed instruction cycle: next-address, instruction fetch, decode, operand address, operand read, execute, result store, and then an interrupt check. For each phase it raises one strobe. The datapath, the ALU and memory sit outside the block. Memory appears only as a request and a ready handshake on one shared read-write port, which serves both instructions and data.

The decoder reports four things during the decode phase: whether the instruction has an operand, whether it has a result to store, whether it returns from a service routine, and whether it enables or disables interrupts. The execute phase reports whether a jump is taken, the jump target, and the new condition flags.

A pending interrupt is looked at only in the check cycle that ends each instruction. When an interrupt is taken, the block saves the resume address and the status word into a shadow pair, one per cycle. It then clears the interrupt enable and starts the next cycle at a fixed service address. A return instruction brings both values back, again one per cycle.

Top module: `icyc_seq`

## Requirements
- R1: A synchronous reset, whether at start or in the middle of an instruction, puts the block in the next-address phase with `pc_o` = 0, `status_o` = 0 (interrupts disabled), `irq_ack` = 0 and `mem_req` = 0.
- R2: `phase_o` is one-hot, with bit 0 next-address, 1 fetch, 2 decode, 3 operand address, 4 operand read, 5 execute, 6 store, 7 interrupt check, 8 save PC, 9 save status, 10 restore PC, 11 restore status. A full instruction steps through bits 0,1,2,3,4,5,6,7 in that order.
- R3: Fetch, operand read and store each last one cycle more than the number of cycles `mem_ready` is held low, and leave in the cycle where `mem_ready` is high. `mem_req` is high in all three of these phases. `mem_we` is high only in store.
- R4: `need_opnd` low at decode makes decode go straight to execute. `need_store` low at decode makes execute go straight to the check cycle.
- R5: The next-address phase sets the PC to PC+1, modulo 2^AW. If `jump_taken` was high in the last execute phase, it sets the PC to the `jump_target` captured there instead. The first address after reset, after vectoring and after a restore is used as it is.
- R6: `irq_pending` is sampled only in the check cycle. At any other time it has no effect.
- R7: In the check cycle, if no return is flagged and either no interrupt is pending or interrupts are disabled, the next phase is next-address.
- R8: In the check cycle, if an interrupt is pending, interrupts are enabled and no return is flagged, the block runs save PC, then save status (with `irq_ack` high), then next-address. It then has `pc_o` = IRQ_VEC and the enable bit clear.
- R9: `rti_dec` high at decode makes the check cycle run restore PC, then restore status, ignoring any pending interrupt. The next instruction then runs at the saved resume address, which is the interrupted instruction's successor or its jump target, and with the saved status word.
- R10: `status_o` bit 0 is the interrupt enable. It is set by `ei_dec` and cleared by `di_dec` at decode, and `di_dec` wins if both are high. Bits SW-1..1 take `flags_in` in the execute phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_ready | input | 1 | Shared memory port has completed the access |
| need_opnd | input | 1 | Decoded instruction has an operand (sampled at decode) |
| need_store | input | 1 | Decoded instruction stores a result (sampled at decode) |
| rti_dec | input | 1 | Decoded instruction returns from service routine |
| ei_dec | input | 1 | Decoded instruction enables interrupts |
| di_dec | input | 1 | Decoded instruction disables interrupts |
| jump_taken | input | 1 | Execute resolved a taken jump |
| jump_target | input | AW | Jump destination address |
| flags_in | input | max(SW-1,1) | Condition flags written at execute |
| irq_pending | input | 1 | An interrupt request is waiting |
| phase_o | output | 12 | One-hot phase strobes |
| mem_req | output | 1 | Memory access in progress |
| mem_we | output | 1 | Access is a write (store phase) |
| irq_ack | output | 1 | Interrupt accepted, vector being loaded |
| pc_o | output | AW | Program counter |
| status_o | output | SW | Status word, bit 0 = interrupt enable |

## Verification
Every phase strobe appears on the rising edge after the input that caused it. A decision made in the check cycle therefore shows up one cycle later, in bit 8 or bit 10 or back in bit 0. A new PC becomes visible in the cycle after the next-address phase, so it is checked in the fetch phase. A vectored or restored PC is visible in the next-address phase that follows the save or restore pair. Flag and enable changes are checked in the cycle after the check cycle. The bench drives each input on a falling edge, holds it for exactly the phase the requirement names, and compares on the next falling edge against a running model of the PC, jump latch, enable, flags and shadow pair.

// File: rtl/icyc_pkg.sv
package icyc_pkg;
   localparam int NPHASE = 12;

   typedef enum logic [3:0] {
      S_ADDR  = 4'd0,
      S_FETCH = 4'd1,
      S_DEC   = 4'd2,
      S_OPADR = 4'd3,
      S_OPRD  = 4'd4,
      S_EXEC  = 4'd5,
      S_STORE = 4'd6,
      S_CHECK = 4'd7,
      S_SVPC  = 4'd8,
      S_SVST  = 4'd9,
      S_RSPC  = 4'd10,
      S_RSST  = 4'd11
   } phase_e;
endpackage

// File: rtl/icyc_ctl.sv
module icyc_ctl
   import icyc_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   mem_ready,
   input  logic   need_opnd,
   input  logic   need_store,
   input  logic   rti_dec,
   input  logic   irq_pending,
   input  logic   ie,
   output phase_e state_o
);
   phase_e state, nxt;
   logic   st_l, rti_l;

   always_comb begin
      nxt = state;
      unique case (state)
         S_ADDR:  nxt = S_FETCH;
         S_FETCH: if (mem_ready) nxt = S_DEC;
         S_DEC:   nxt = need_opnd ? S_OPADR : S_EXEC;
         S_OPADR: nxt = S_OPRD;
         S_OPRD:  if (mem_ready) nxt = S_EXEC;
         S_EXEC:  nxt = st_l ? S_STORE : S_CHECK;
         S_STORE: if (mem_ready) nxt = S_CHECK;
         S_CHECK: begin
            if (rti_l)                  nxt = S_RSPC;
            else if (irq_pending && ie) nxt = S_SVPC;
            else                        nxt = S_ADDR;
         end
         S_SVPC:  nxt = S_SVST;
         S_SVST:  nxt = S_ADDR;
         S_RSPC:  nxt = S_RSST;
         S_RSST:  nxt = S_ADDR;
         default: nxt = S_ADDR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= S_ADDR;
         st_l  <= 1'b0;
         rti_l <= 1'b0;
      end else begin
         state <= nxt;
         if (state == S_DEC) begin
            st_l  <= need_store;
            rti_l <= rti_dec;
         end
      end
   end

   assign state_o = state;

   AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
      (state == S_FETCH && !mem_ready) |=> state == S_FETCH); // R3
   AST_DEC_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
      (state == S_DEC) |-> $past(state) == S_FETCH); // R2
   AST_SKIP_OPND: assert property (@(posedge clk) disable iff (rst)
      (state == S_DEC && !need_opnd) |=> state == S_EXEC); // R4
   AST_SAVE_ONLY_AT_CHECK: assert property (@(posedge clk) disable iff (rst)
      (state == S_SVPC) |-> ($past(state) == S_CHECK && $past(irq_pending) && $past(ie))); // R6
   AST_DISABLED_NO_SAVE: assert property (@(posedge clk) disable iff (rst)
      (state == S_CHECK && !ie && !rti_l) |=> state == S_ADDR); // R7
endmodule

// File: rtl/icyc_pcu.sv
module icyc_pcu
   import icyc_pkg::*;
#(
   parameter int AW = 8,
   parameter logic [AW-1:0] VEC = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  phase_e        state,
   input  logic          jump_taken,
   input  logic [AW-1:0] jump_target,
   output logic [AW-1:0] pc_o
);
   logic [AW-1:0] pc, jmp_tgt, sh_pc, nxt_addr;
   logic          hold, jmp_pend;

   assign nxt_addr = jmp_pend ? jmp_tgt : pc + AW'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         pc       <= '0;
         hold     <= 1'b1;
         jmp_pend <= 1'b0;
         jmp_tgt  <= '0;
         sh_pc    <= '0;
      end else begin
         unique case (state)
            S_ADDR: begin
               if (!hold) pc <= nxt_addr;
               hold <= 1'b0;
            end
            S_EXEC: begin
               jmp_pend <= jump_taken;
               jmp_tgt  <= jump_target;
            end
            S_SVPC: sh_pc <= nxt_addr;
            S_SVST: begin
               pc   <= VEC;
               hold <= 1'b1;
            end
            S_RSPC: begin
               pc   <= sh_pc;
               hold <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign pc_o = pc;

   AST_PC_ONLY_IN_LOAD_PHASES: assert property (@(posedge clk) disable iff (rst)
      !(state inside {S_ADDR, S_SVST, S_RSPC}) |=> pc == $past(pc)); // R5
   AST_VEC_LOAD: assert property (@(posedge clk) disable iff (rst)
      (state == S_SVST) |=> pc == VEC); // R8
   AST_RESTORE_PC: assert property (@(posedge clk) disable iff (rst)
      (state == S_RSPC) |=> pc == $past(sh_pc)); // R9
endmodule

// File: rtl/icyc_stat.sv
module icyc_stat
   import icyc_pkg::*;
#(
   parameter  int SW = 4,
   localparam int FW = (SW > 1) ? SW - 1 : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  phase_e        state,
   input  logic          ei_dec,
   input  logic          di_dec,
   input  logic [FW-1:0] flags_in,
   output logic [SW-1:0] stat_o
);
   logic [SW-1:0] stat_q, sh_st, exec_val;

   generate
      if (SW > 1) begin : g_flags
         assign exec_val = {flags_in[SW-2:0], stat_q[0]};
      end else begin : g_ie_only
         assign exec_val = stat_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         stat_q <= '0;
         sh_st  <= '0;
      end else begin
         unique case (state)
            S_DEC: begin
               if (di_dec)      stat_q[0] <= 1'b0;
               else if (ei_dec) stat_q[0] <= 1'b1;
            end
            S_EXEC: stat_q <= exec_val;
            S_SVST: begin
               sh_st     <= stat_q;
               stat_q[0] <= 1'b0;
            end
            S_RSST: stat_q <= sh_st;
            default: ;
         endcase
      end
   end

   assign stat_o = stat_q;

   AST_IE_CLR_ON_VEC: assert property (@(posedge clk) disable iff (rst)
      (state == S_SVST) |=> !stat_q[0]); // R8
   AST_DI_WINS: assert property (@(posedge clk) disable iff (rst)
      (state == S_DEC && di_dec) |=> !stat_q[0]); // R10
   AST_RESTORE_ST: assert property (@(posedge clk) disable iff (rst)
      (state == S_RSST) |=> stat_q == $past(sh_st)); // R9
endmodule

// File: rtl/icyc_seq.sv
module icyc_seq
   import icyc_pkg::*;
#(
   parameter  int AW      = 8,
   parameter  int SW      = 4,
   parameter  int IRQ_VEC = 192,
   localparam int FW      = (SW > 1) ? SW - 1 : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mem_ready,
   input  logic              need_opnd,
   input  logic              need_store,
   input  logic              rti_dec,
   input  logic              ei_dec,
   input  logic              di_dec,
   input  logic              jump_taken,
   input  logic [AW-1:0]     jump_target,
   input  logic [FW-1:0]     flags_in,
   input  logic              irq_pending,
   output logic [NPHASE-1:0] phase_o,
   output logic              mem_req,
   output logic              mem_we,
   output logic              irq_ack,
   output logic [AW-1:0]     pc_o,
   output logic [SW-1:0]     status_o
);
   if (AW < 2 || AW > 30) begin : g_bad_aw
      $error("icyc_seq: AW must lie in 2..30");
   end
   if (SW < 1) begin : g_bad_sw
      $error("icyc_seq: SW must be at least 1");
   end
   if (IRQ_VEC < 0 || IRQ_VEC >= (1 << AW)) begin : g_bad_vec
      $error("icyc_seq: IRQ_VEC does not fit in AW bits");
   end

   localparam logic [AW-1:0] VEC = AW'(IRQ_VEC);

   phase_e        state;
   logic [SW-1:0] stat;

   icyc_ctl u_ctl (
      .clk         (clk),
      .rst         (rst),
      .mem_ready   (mem_ready),
      .need_opnd   (need_opnd),
      .need_store  (need_store),
      .rti_dec     (rti_dec),
      .irq_pending (irq_pending),
      .ie          (stat[0]),
      .state_o     (state)
   );

   icyc_pcu #(.AW(AW), .VEC(VEC)) u_pcu (
      .clk         (clk),
      .rst         (rst),
      .state       (state),
      .jump_taken  (jump_taken),
      .jump_target (jump_target),
      .pc_o        (pc_o)
   );

   icyc_stat #(.SW(SW)) u_stat (
      .clk      (clk),
      .rst      (rst),
      .state    (state),
      .ei_dec   (ei_dec),
      .di_dec   (di_dec),
      .flags_in (flags_in),
      .stat_o   (stat)
   );

   assign status_o = stat;
   assign phase_o  = NPHASE'(1) << state;
   assign mem_req  = (state == S_FETCH) || (state == S_OPRD) || (state == S_STORE);
   assign mem_we   = (state == S_STORE);
   assign irq_ack  = (state == S_SVST);

   AST_ACK_THEN_VEC: assert property (@(posedge clk) disable iff (rst)
      irq_ack |=> (pc_o == VEC && phase_o[0] && !status_o[0])); // R8
   AST_CHECK_ENDS_INSTR: assert property (@(posedge clk) disable iff (rst)
      phase_o[7] |-> ($past(phase_o[6]) || $past(phase_o[5]))); // R2
   AST_STORE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (mem_we && !mem_ready) |=> mem_we); // R3
endmodule

// File: tb/sim_icyc_seq.sv
module sim_icyc_seq;
   localparam int AW  = 8;
   localparam int SW  = 4;
   localparam int VEC = 192;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          mem_ready = 0, need_opnd = 0, need_store = 0, rti_dec = 0;
   logic          ei_dec = 0, di_dec = 0, jump_taken = 0, irq_pending = 0;
   logic [AW-1:0] jump_target = '0;
   logic [2:0]    flags_in = '0;
   logic [11:0]   phase_o;
   logic          mem_req, mem_we, irq_ack;
   logic [AW-1:0] pc_o;
   logic [SW-1:0] status_o;

   int tests = 0;
   int fails = 0;

   // bench model
   logic [AW-1:0] exp_pc = '0, sh_pc = '0, jt = '0;
   logic [2:0]    flg = '0;
   logic [3:0]    sh_st = '0;
   bit            jp = 0, hold = 1, ie = 0;

   always #10 clk = ~clk;

   icyc_seq #(.AW(AW), .SW(SW), .IRQ_VEC(VEC)) u0 (
      .clk(clk), .rst(rst), .mem_ready(mem_ready), .need_opnd(need_opnd),
      .need_store(need_store), .rti_dec(rti_dec), .ei_dec(ei_dec), .di_dec(di_dec),
      .jump_taken(jump_taken), .jump_target(jump_target), .flags_in(flags_in),
      .irq_pending(irq_pending), .phase_o(phase_o), .mem_req(mem_req), .mem_we(mem_we),
      .irq_ack(irq_ack), .pc_o(pc_o), .status_o(status_o));

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] nxt_addr();
      return jp ? jt : exp_pc + AW'(1);
   endfunction

   task automatic mem_phase(input int bitn, input string req, input int lat, input bit we);
      for (int i = 0; i < lat; i++) begin
         mem_ready = 1'b0;
         check(req, "phase while waiting", phase_o, 32'(1) << bitn);
         check("R3", "mem_req while waiting", mem_req, 1);
         @(negedge clk);
      end
      mem_ready = 1'b1;
      check(req, "phase on ready", phase_o, 32'(1) << bitn);
      check("R3", "mem_we", mem_we, we);
      @(negedge clk);
      mem_ready = 1'b0;
   endtask

   task automatic instr(input bit op, input bit st, input bit jmp, input logic [AW-1:0] tgt,
                        input bit ei, input bit di, input bit rti, input bit irq,
                        input bit mid_irq, input int lat, input logic [2:0] f);
      check("R2", "next-address phase", phase_o, 1);
      if (!hold) exp_pc = nxt_addr();
      hold = 0;
      @(negedge clk);
      check("R5", "pc at fetch", pc_o, exp_pc);
      irq_pending = mid_irq;
      mem_phase(1, "R2", lat, 0);
      check("R2", "decode phase", phase_o, 4);
      need_opnd = op; need_store = st; ei_dec = ei; di_dec = di; rti_dec = rti;
      @(negedge clk);
      need_opnd = 0; need_store = 0; ei_dec = 0; di_dec = 0; rti_dec = 0;
      if (di) ie = 0; else if (ei) ie = 1;
      if (op) begin
         check("R4", "operand address phase", phase_o, 8);
         @(negedge clk);
         mem_phase(4, "R4", lat, 0);
      end
      check(op ? "R2" : "R4", "execute phase", phase_o, 32);
      jump_taken = jmp; jump_target = tgt; flags_in = f;
      @(negedge clk);
      jump_taken = 0; flags_in = '0; irq_pending = 0;
      jp = jmp; jt = tgt; flg = f;
      if (st) mem_phase(6, "R4", lat, 1);
      check(st ? "R2" : "R4", "check phase", phase_o, 128);
      irq_pending = irq;
      @(negedge clk);
      irq_pending = 0;
      if (rti) begin
         check("R9", "restore pc phase", phase_o, 1024);
         @(negedge clk);
         check("R9", "restore status phase", phase_o, 2048);
         @(negedge clk);
         exp_pc = sh_pc; hold = 1;
         ie = sh_st[0]; flg = sh_st[3:1];
         check("R9", "pc after restore", pc_o, exp_pc);
         check("R9", "status after restore", status_o, {flg, ie});
      end else if (irq && ie) begin
         check("R8", "save pc phase", phase_o, 256);
         @(negedge clk);
         check("R8", "save status phase", phase_o, 512);
         check("R8", "irq_ack", irq_ack, 1);
         sh_pc = nxt_addr(); sh_st = {flg, ie};
         @(negedge clk);
         ie = 0; exp_pc = AW'(VEC); hold = 1;
         check("R8", "pc after vector", pc_o, exp_pc);
      end else begin
         check(irq ? "R7" : "R6", "back to next-address", phase_o, 1);
         check("R6", "no irq_ack", irq_ack, 0);
      end
      check("R10", "status word", status_o, {flg, ie});
   endtask

   task automatic reset_model();
      exp_pc = '0; jp = 0; hold = 1; ie = 0; flg = '0; sh_pc = '0; sh_st = '0;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "reset phase", phase_o, 1);
      check("R1", "reset pc", pc_o, 0);
      check("R1", "reset status", status_o, 0);
      check("R1", "reset irq_ack", irq_ack, 0);
      check("R1", "reset mem_req", mem_req, 0);
      rst = 1'b0;
      // R2 R3 R4 R5 R7: sweep shapes, latencies and jumps with interrupts disabled
      for (int op = 0; op < 2; op++)
         for (int st = 0; st < 2; st++)
            for (int j = 0; j < 2; j++)
               for (int lat = 0; lat < 3; lat++)
                  instr(op[0], st[0], j[0], AW'(16 + 8 * op + 4 * st + lat), 0, 0, 0, 1, 0,
                        lat, 3'(op + 2 * st + lat));
      // R5 wrap
      instr(0, 0, 1, 8'hFF, 0, 0, 0, 0, 0, 0, 3'd1);
      instr(0, 0, 0, 8'h00, 0, 0, 0, 0, 0, 1, 3'd2);
      // R10 enable, R6 mid-instruction request ignored
      instr(0, 0, 0, 8'h00, 1, 0, 0, 0, 1, 1, 3'd5);
      instr(1, 1, 0, 8'h00, 0, 0, 0, 0, 1, 2, 3'd6);
      // R8 take interrupt after a jump
      instr(1, 1, 1, 8'h40, 0, 0, 0, 1, 0, 1, 3'd3);
      // R7 nested request while disabled inside service routine
      instr(0, 1, 0, 8'h00, 0, 0, 0, 1, 0, 0, 3'd7);
      // R9 return with request pending: restore wins
      instr(0, 0, 0, 8'h00, 0, 0, 1, 1, 0, 0, 3'd0);
      // R8 again without jump, then R9 restore
      instr(0, 0, 0, 8'h00, 0, 0, 0, 1, 0, 0, 3'd4);
      instr(1, 0, 0, 8'h00, 0, 0, 1, 0, 0, 1, 3'd2);
      // R10 both enable and disable: disable wins, request then ignored
      instr(0, 0, 0, 8'h00, 1, 1, 0, 1, 0, 0, 3'd1);
      // R1 reset in the middle of an instruction
      check("R2", "next-address phase", phase_o, 1);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      reset_model();
      check("R1", "mid reset phase", phase_o, 1);
      check("R1", "mid reset pc", pc_o, 0);
      check("R1", "mid reset status", status_o, 0);
      instr(0, 0, 0, 8'h00, 0, 0, 0, 1, 0, 0, 3'd0);
      finish_run();
   end
endmodule